// File: doc/BRIEF.md
# Prioritized Maskable Interrupt Controller

This block gathers a set of interrupt request lines and one non-maskable line into a single request to a processor, together with the index of the handler the processor should run. Every maskable source can be blocked by a mask bit and can be configured as edge-sensitive or level-sensitive. A readable pending view and a readable in-service view let software see which sources asked for service and which are being handled.

Selection uses fixed priority: the non-maskable line ranks above every maskable source, and among maskable sources a lower index wins. A request interrupts the processor only when it outranks every source already in service, so a more urgent source can preempt a running handler. A less urgent one waits until the handlers above it finish. The processor takes a request with an acknowledge strobe, which returns the vector index and marks that source as in service. It signals that a handler has finished with an end-of-interrupt strobe, which retires the most urgent in-service source.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset the request output is low and the presented vector is the all-ones idle code (15 with default parameters). The mask and trigger registers read zero, so all sources start unmasked and level-sensitive. The pending and in-service views also read zero.
- R2: A write with select 0 loads the mask register, where a 1 blocks the source. A write with select 1 loads the trigger register, where a 1 means edge and a 0 means level. The read data is registered and shows, one clock after the read select, the mask (select 0), the trigger (1), the pending view (2) or the in-service view (3), with bit i belonging to source i.
- R3: An edge-sensitive source latches its pending bit on a rising transition of its line. The bit stays set after the line falls and clears only when that source is acknowledged.
- R4: A level-sensitive source is pending exactly while its line is high; dropping the line withdraws the request.
- R5: A masked source is never presented. An edge-sensitive source still records its pending bit while masked and is presented once it is unmasked.
- R6: Among maskable sources, the lowest index has the highest priority, and the vector index of source i is i.
- R7: The non-maskable line is edge-latched, ignores the mask, has vector index NUM_SRC (8 by default) and outranks every maskable source.
- R8: An acknowledge returns the current winner's vector on the acknowledge-vector output one clock later, sets that source's in-service bit and clears its edge-latched pending bit. An acknowledge with nothing presentable returns the all-ones code and changes no state.
- R9: A request is presented only if it outranks every in-service source. A lower or equal request stays pending and is presented once the sources above it are retired.
- R10: An end-of-interrupt clears only the highest-priority in-service bit.
- R11: The request output and the presented vector are registered. A level request that is high before a rising clock edge is visible on the request output after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_lines | input | NUM_SRC | Maskable request lines, one per source |
| nmi_line | input | 1 | Non-maskable request line, rising-edge sensitive |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | Write target: 0 mask, 1 trigger type |
| cfg_wdata | input | NUM_SRC | Configuration write data |
| rd_sel | input | 2 | Read view: 0 mask, 1 trigger, 2 pending, 3 in-service |
| rd_data | output | NUM_SRC | Registered read data |
| ack | input | 1 | Acknowledge strobe from the processor |
| eoi | input | 1 | End-of-interrupt strobe from the processor |
| irq_out | output | 1 | Interrupt request to the processor |
| irq_vec | output | VEC_W | Vector index currently presented, all ones when idle |
| ack_vec | output | VEC_W | Vector index returned by the last acknowledge |

## Verification
The first visible symptom of a corrupted in-service set is a request that should be held back but reaches irq_out, or a deferred request that never comes back after an end-of-interrupt. Either shows on the port one clock after the strobe that caused it. A lost or stuck edge latch shows up in the pending read view on the next read, and in irq_vec one clock after the mask or the in-service set allows that source. A wrong priority order shows as a wrong irq_vec or ack_vec on the cycle that follows the request. The stimulus drives nested acknowledges, deferred lower requests, level lines that are dropped, masked edges and spurious acknowledges, so each of these faults appears within a few cycles.

// File: rtl/pic_pkg.sv
package pic_pkg;
  typedef enum logic [1:0] {
    SEL_MASK = 2'd0,
    SEL_TRIG = 2'd1,
    SEL_PEND = 2'd2,
    SEL_INSV = 2'd3
  } pic_sel_e;
endpackage

// File: rtl/pic_prio_enc.sv
// Finds the lowest set bit; a lower index means a higher priority.
module pic_prio_enc #(
  parameter int W  = 9,
  parameter int IW = 4
) (
  input  logic [W-1:0]  req,
  output logic          hit,
  output logic [IW-1:0] idx
);
  always_comb begin
    hit = |req;
    idx = '0;
    for (int i = W - 1; i >= 0; i--) begin
      if (req[i]) idx = IW'(i);
    end
  end
endmodule

// File: rtl/pic_cfg_regs.sv
// Mask and trigger-type registers.
module pic_cfg_regs
  import pic_pkg::*;
#(
  parameter int NUM_SRC = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               we,
  input  logic [1:0]         sel,
  input  logic [NUM_SRC-1:0] wdata,
  output logic [NUM_SRC-1:0] mask_q,
  output logic [NUM_SRC-1:0] trig_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      mask_q <= '0;
      trig_q <= '0;
    end else if (we) begin
      if (pic_sel_e'(sel) == SEL_MASK) mask_q <= wdata;
      if (pic_sel_e'(sel) == SEL_TRIG) trig_q <= wdata;
    end
  end
endmodule

// File: rtl/pic_req_stage.sv
// Edge latching, level pass-through and masking. Extended bit 0 is the
// non-maskable source; extended bit i+1 is maskable source i.
module pic_req_stage #(
  parameter int NUM_SRC = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] lines,
  input  logic               nmi_line,
  input  logic [NUM_SRC-1:0] trig,
  input  logic [NUM_SRC-1:0] mask,
  input  logic [NUM_SRC-1:0] clr_src,
  input  logic               clr_nmi,
  output logic [NUM_SRC-1:0] raw_pend,
  output logic [NUM_SRC:0]   req_ext
);
  logic [NUM_SRC-1:0] line_d;
  logic [NUM_SRC-1:0] edge_pend;
  logic               nmi_d;
  logic               nmi_pend;

  always_ff @(posedge clk) begin
    if (rst) begin
      line_d <= '0;
      nmi_d  <= 1'b0;
    end else begin
      line_d <= lines;
      nmi_d  <= nmi_line;
    end
  end

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
    always_ff @(posedge clk) begin
      if (rst || !trig[g])                edge_pend[g] <= 1'b0;
      else if (lines[g] && !line_d[g])    edge_pend[g] <= 1'b1;
      else if (clr_src[g])                edge_pend[g] <= 1'b0;
    end
    assign raw_pend[g] = trig[g] ? edge_pend[g] : lines[g];
  end

  always_ff @(posedge clk) begin
    if (rst)                        nmi_pend <= 1'b0;
    else if (nmi_line && !nmi_d)    nmi_pend <= 1'b1;
    else if (clr_nmi)               nmi_pend <= 1'b0;
  end

  assign req_ext = {raw_pend & ~mask, nmi_pend};
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
  import pic_pkg::*;
#(
  parameter int NUM_SRC = 8,
  parameter int VEC_W   = $clog2(NUM_SRC + 2)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] irq_lines,
  input  logic               nmi_line,
  input  logic               cfg_we,
  input  logic [1:0]         cfg_sel,
  input  logic [NUM_SRC-1:0] cfg_wdata,
  input  logic [1:0]         rd_sel,
  output logic [NUM_SRC-1:0] rd_data,
  input  logic               ack,
  input  logic               eoi,
  output logic               irq_out,
  output logic [VEC_W-1:0]   irq_vec,
  output logic [VEC_W-1:0]   ack_vec
);
  localparam int EXT = NUM_SRC + 1;
  localparam int RW  = $clog2(EXT);
  localparam logic [VEC_W-1:0] IDLE_VEC = '1;
  localparam logic [VEC_W-1:0] NMI_VEC  = VEC_W'(NUM_SRC);

  logic [NUM_SRC-1:0] mask_q, trig_q, raw_pend, clr_src;
  logic [EXT-1:0]     req_ext, isr, win_onehot, top_onehot;
  logic               req_hit, isr_hit, present, clr_nmi;
  logic [RW-1:0]      req_idx, isr_idx;
  logic [VEC_W-1:0]   win_vec;

  pic_cfg_regs #(.NUM_SRC(NUM_SRC)) u_cfg (
    .clk(clk), .rst(rst), .we(cfg_we), .sel(cfg_sel), .wdata(cfg_wdata),
    .mask_q(mask_q), .trig_q(trig_q)
  );

  pic_req_stage #(.NUM_SRC(NUM_SRC)) u_req (
    .clk(clk), .rst(rst), .lines(irq_lines), .nmi_line(nmi_line),
    .trig(trig_q), .mask(mask_q), .clr_src(clr_src), .clr_nmi(clr_nmi),
    .raw_pend(raw_pend), .req_ext(req_ext)
  );

  pic_prio_enc #(.W(EXT), .IW(RW)) u_req_enc (
    .req(req_ext), .hit(req_hit), .idx(req_idx)
  );

  pic_prio_enc #(.W(EXT), .IW(RW)) u_isr_enc (
    .req(isr), .hit(isr_hit), .idx(isr_idx)
  );

  // Strictly higher than everything in service, or nothing in service.
  assign present    = req_hit && (!isr_hit || (req_idx < isr_idx));
  assign win_vec    = (req_idx == '0) ? NMI_VEC : VEC_W'(req_idx - 1'b1);
  assign win_onehot = present ? (EXT'(1) << req_idx) : '0;
  assign top_onehot = isr_hit ? (EXT'(1) << isr_idx) : '0;
  assign clr_nmi    = ack && win_onehot[0];
  assign clr_src    = ack ? win_onehot[EXT-1:1] : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      isr <= '0;
    end else begin
      isr <= (isr & ~(eoi ? top_onehot : '0)) | (ack ? win_onehot : '0);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_out <= 1'b0;
      irq_vec <= IDLE_VEC;
      ack_vec <= IDLE_VEC;
      rd_data <= '0;
    end else begin
      irq_out <= present;
      irq_vec <= present ? win_vec : IDLE_VEC;
      if (ack) ack_vec <= present ? win_vec : IDLE_VEC;
      case (pic_sel_e'(rd_sel))
        SEL_MASK: rd_data <= mask_q;
        SEL_TRIG: rd_data <= trig_q;
        SEL_PEND: rd_data <= raw_pend;
        default:  rd_data <= isr[EXT-1:1];
      endcase
    end
  end
endmodule

// File: rtl/prio_irq_ctrl_chk.sv
module prio_irq_ctrl_chk #(
  parameter int NUM_SRC = 8,
  parameter int VEC_W   = 4
) (
  input logic               clk,
  input logic               rst,
  input logic               ack,
  input logic               eoi,
  input logic               present,
  input logic               nmi_req,
  input logic [NUM_SRC:0]   isr,
  input logic [NUM_SRC-1:0] mask,
  input logic               irq_out,
  input logic [VEC_W-1:0]   irq_vec,
  input logic [VEC_W-1:0]   ack_vec
);
  localparam int SW = $clog2(NUM_SRC);
  logic [NUM_SRC-1:0] mask_prev;
  logic               blocked;

  always_ff @(posedge clk) begin
    if (rst) mask_prev <= '0;
    else     mask_prev <= mask;
  end

  always_comb begin
    blocked = 1'b0;
    if (irq_vec < VEC_W'(NUM_SRC)) blocked = mask_prev[irq_vec[SW-1:0]];
  end

  // R1: idle code is shown exactly when no request is raised
  a_r1_idle_code: assert property (@(posedge clk) disable iff (rst)
    irq_out == (irq_vec != '1));

  // R5: a presented maskable source was unmasked when it was chosen
  a_r5_mask_blocks: assert property (@(posedge clk) disable iff (rst)
    irq_out |-> !blocked);

  // R7: a latched non-maskable request not in service is presented next cycle
  a_r7_nmi_wins: assert property (@(posedge clk) disable iff (rst)
    (nmi_req && !isr[0]) |=> (irq_out && irq_vec == VEC_W'(NUM_SRC)));

  // R8: acknowledge with nothing presentable returns the idle code
  a_r8_spurious_ack: assert property (@(posedge clk) disable iff (rst)
    (ack && !present) |=> (ack_vec == '1));

  // R8: acknowledge of a winner adds exactly one in-service bit
  a_r8_ack_marks: assert property (@(posedge clk) disable iff (rst)
    (ack && present && !eoi) |=> ($countones(isr) == $countones($past(isr)) + 1));

  // R10: end-of-interrupt retires exactly one in-service bit
  a_r10_eoi_one: assert property (@(posedge clk) disable iff (rst)
    (eoi && !ack && isr != '0) |=> ($countones(isr) + 1 == $countones($past(isr))));
endmodule

bind prio_irq_ctrl prio_irq_ctrl_chk #(.NUM_SRC(NUM_SRC), .VEC_W(VEC_W)) u_chk (
  .clk(clk), .rst(rst), .ack(ack), .eoi(eoi), .present(present),
  .nmi_req(req_ext[0]), .isr(isr), .mask(mask_q), .irq_out(irq_out),
  .irq_vec(irq_vec), .ack_vec(ack_vec)
);

// File: tb/tb_prio_irq_ctrl.sv
module tb_prio_irq_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int N  = 8;
  localparam int VW = 4;

  logic          clk = 1'b0;
  logic          rst;
  logic [N-1:0]  irq_lines;
  logic          nmi_line;
  logic          cfg_we;
  logic [1:0]    cfg_sel;
  logic [N-1:0]  cfg_wdata;
  logic [1:0]    rd_sel;
  logic [N-1:0]  rd_data;
  logic          ack, eoi;
  logic          irq_out;
  logic [VW-1:0] irq_vec, ack_vec;

  int errors = 0;
  int checks = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  prio_irq_ctrl #(.NUM_SRC(N), .VEC_W(VW)) dut (
    .clk(clk), .rst(rst), .irq_lines(irq_lines), .nmi_line(nmi_line),
    .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .rd_sel(rd_sel), .rd_data(rd_data), .ack(ack), .eoi(eoi),
    .irq_out(irq_out), .irq_vec(irq_vec), .ack_vec(ack_vec)
  );

  // Row: lines[15:8], nmi[7], op[6:5] (0 none, 1 ack, 2 eoi), irq[4], vec[3:0]
  // Sources 0..3 edge, 4..7 level during the table.
  localparam logic [15:0] TAB [0:15] = '{
    {8'h00, 1'b0, 2'd0, 1'b0, 4'd15}, // R1 idle
    {8'h20, 1'b0, 2'd0, 1'b1, 4'd5},  // R4 level src5
    {8'h20, 1'b0, 2'd1, 1'b0, 4'd5},  // R8 ack src5
    {8'h28, 1'b0, 2'd0, 1'b1, 4'd3},  // R9 src3 edge nests above 5
    {8'h28, 1'b0, 2'd1, 1'b0, 4'd3},  // R8 ack src3
    {8'h68, 1'b0, 2'd0, 1'b0, 4'd15}, // R9 src6 deferred
    {8'h68, 1'b0, 2'd2, 1'b0, 4'd15}, // R10 eoi retires 3 only
    {8'h68, 1'b0, 2'd2, 1'b1, 4'd5},  // R10 eoi retires 5, R6 5 over 6
    {8'h48, 1'b0, 2'd0, 1'b1, 4'd6},  // R4 drop src5
    {8'h48, 1'b1, 2'd0, 1'b1, 4'd8},  // R7 nmi above all
    {8'h48, 1'b1, 2'd1, 1'b0, 4'd8},  // R8 ack nmi
    {8'h48, 1'b1, 2'd2, 1'b1, 4'd6},  // R9 deferred src6 returns
    {8'h48, 1'b1, 2'd1, 1'b0, 4'd6},  // R8 ack src6
    {8'h48, 1'b1, 2'd2, 1'b1, 4'd6},  // R4 level still high
    {8'h00, 1'b1, 2'd0, 1'b0, 4'd15}, // R4 level withdrawn
    {8'h00, 1'b0, 2'd1, 1'b0, 4'd15}  // R8 spurious ack
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic settle();
    repeat (3) @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] sel, input logic [N-1:0] d);
    cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic rd_check(input string tag, input logic [1:0] sel, input logic [N-1:0] exp);
    rd_sel = sel;
    @(negedge clk);
    check(tag, 32'(rd_data), 32'(exp));
  endtask

  task automatic pulse(input logic [1:0] op);
    if (op == 2'd1) ack = 1'b1;
    if (op == 2'd2) eoi = 1'b1;
    @(negedge clk);
    ack = 1'b0; eoi = 1'b0;
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    rst = 1'b1; irq_lines = '0; nmi_line = 1'b0; cfg_we = 1'b0;
    cfg_sel = '0; cfg_wdata = '0; rd_sel = '0; ack = 1'b0; eoi = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1 irq_out after reset", 32'(irq_out), 0);
    check("R1 irq_vec after reset", 32'(irq_vec), 15);
    rd_check("R1 mask reset", 2'd0, 8'h00);
    rd_check("R1 trig reset", 2'd1, 8'h00);
    rd_check("R1 pend reset", 2'd2, 8'h00);
    rd_check("R1 insv reset", 2'd3, 8'h00);

    // R11: level request visible right after one rising edge
    irq_lines = 8'h10;
    check("R11 irq before edge", 32'(irq_out), 0);
    @(negedge clk);
    check("R11 irq after one edge", 32'(irq_out), 1);
    check("R11 vec after one edge", 32'(irq_vec), 4);
    irq_lines = 8'h00;
    @(negedge clk);
    check("R4 level drop withdraws", 32'(irq_out), 0);

    wr(2'd1, 8'h0F);
    rd_check("R2 trig readback", 2'd1, 8'h0F);

    for (int i = 0; i < 16; i++) begin
      irq_lines = TAB[i][15:8];
      nmi_line  = TAB[i][7];
      settle();
      if (TAB[i][6:5] != 2'd0) begin
        pulse(TAB[i][6:5]);
        settle();
      end
      check($sformatf("table row %0d irq_out", i), 32'(irq_out), 32'(TAB[i][4]));
      if (TAB[i][6:5] == 2'd1)
        check($sformatf("table row %0d ack_vec", i), 32'(ack_vec), 32'(TAB[i][3:0]));
      else
        check($sformatf("table row %0d irq_vec", i), 32'(irq_vec), 32'(TAB[i][3:0]));
    end

    // R5: masked edge is recorded but not presented
    wr(2'd0, 8'hFF);
    rd_check("R2 mask readback", 2'd0, 8'hFF);
    irq_lines = 8'h02;
    settle();
    check("R5 masked src1 not presented", 32'(irq_out), 0);
    rd_check("R5 masked edge recorded", 2'd2, 8'h02);
    irq_lines = 8'h00;
    settle();
    rd_check("R3 edge pending held after fall", 2'd2, 8'h02);

    // R7: NMI ignores the mask
    nmi_line = 1'b1;
    settle();
    check("R7 nmi irq under full mask", 32'(irq_out), 1);
    check("R7 nmi vector", 32'(irq_vec), 8);
    pulse(2'd1);
    settle();
    check("R8 ack nmi vector", 32'(ack_vec), 8);
    pulse(2'd2);
    settle();
    check("R10 after eoi masked src quiet", 32'(irq_out), 0);

    // R5: unmasking presents the latched edge
    wr(2'd0, 8'h00);
    settle();
    check("R5 unmasked src1 irq", 32'(irq_out), 1);
    check("R5 unmasked src1 vec", 32'(irq_vec), 1);

    // R6/R8/R9: src1 edge vs src7 level
    irq_lines = 8'h80;
    settle();
    check("R6 src1 beats src7", 32'(irq_vec), 1);
    pulse(2'd1);
    settle();
    check("R8 ack returns src1", 32'(ack_vec), 1);
    rd_check("R8 in-service src1", 2'd3, 8'h02);
    rd_check("R3 ack clears edge pend", 2'd2, 8'h80);
    check("R9 src7 deferred", 32'(irq_out), 0);
    pulse(2'd2);
    settle();
    check("R9 src7 after eoi irq", 32'(irq_out), 1);
    check("R9 src7 after eoi vec", 32'(irq_vec), 7);
    rd_check("R10 in-service empty", 2'd3, 8'h00);

    finish_run();
  end
endmodule